// File: doc/BRIEF.md
# Four-Mode Serial Port with Majority-Vote Receive

This block is a serial port with four frame modes. Mode 0 is synchronous and transmit-only. Eight bits leave on the data pin, least significant bit first. A shift clock is driven on a second pin, and its period is a fixed number of system clocks. Modes 1 to 3 are asynchronous full-duplex. Mode 1 uses a 10-bit frame (start, eight data, stop). Modes 2 and 3 use an 11-bit frame, in which a ninth data bit comes from a control bit and is received into a status bit. Mode 2 times its bits from a fixed divide of the system clock. Modes 1 and 3 time their bits from a programmable divider.

The receiver oversamples each bit sixteen times. It takes three consecutive samples around the middle of the bit and keeps the majority value. A start bit whose middle votes high is treated as noise, and the receiver returns to hunting. A finished byte moves from the shift register into a holding buffer only when the receive flag is clear. A stop bit that votes low records a framing error. When the error view is enabled, that flag is visible in the top bit of the control register in place of the high mode bit.

Software uses a small register port. The port has four locations: control, configuration, data and baud divisor. Writing 0 to a flag bit clears that flag.

Top module: `usart_core`

## Requirements
- R1: After reset, txd and shclk are 1, both interrupt outputs are 0, and reads return 0 from the control location (sel 0) and from the data location (sel 2).
- R2: Control bits [7:6] select the mode (00 sync, 01 async 10-bit, 10 async 11-bit at fixed rate, 11 async 11-bit at programmable rate). In mode 0, a write to sel 2 sends eight bits LSB first on txd. Each bit is valid at a rising edge of shclk, and the rising edges are SYNC_DIV clocks apart. After the eighth bit, the transmit flag (control bit 2) is set, and txd and shclk return high.
- R3: In mode 1, a write to sel 2 sends a 0 start bit, eight data bits LSB first and a 1 stop bit. Each bit lasts 16 ticks, and a tick occurs every (divisor+1) clocks, where the divisor is written at sel 3.
- R4: Modes 2 and 3 send an 11-bit frame whose ninth bit is control bit 4. The tick period is FIX_DIV clocks in mode 2 and (divisor+1) clocks in mode 3.
- R5: In the asynchronous modes, the transmit flag is still 0 during the last data bit and is 1 once the stop bit has begun.
- R6: The receiver decides each bit from the majority of the samples at ticks 7, 8 and 9 of that bit. A disturbance shorter than one tick period does not change the received byte.
- R7: A low pulse on rxd whose mid-bit majority is high is rejected as a false start. No byte is received.
- R8: A received byte is readable at sel 2. Control bit 3 takes the ninth bit in modes 2 and 3 and the stop bit in mode 1. The receive flag (control bit 1) is set.
- R9: If the receive flag is already set when a frame ends, the buffer and control bit 3 keep their old values.
- R10: A stop bit that samples low sets a framing-error flag. When configuration bit 0 (sel 1) is 1, control bit 7 reads that flag, and writing 0 to control bit 7 clears it. The flag stays set through later good frames. When configuration bit 0 is 0, control bit 7 reads the high mode bit.
- R11: The receiver accepts frames only while control bit 5 is 1.
- R12: A write to sel 2 while a frame is being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register location: 0 control, 1 configuration, 2 data, 3 baud divisor |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected location |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line (data pin in mode 0) |
| shclk | output | 1 | Shift clock in mode 0, high otherwise |
| rx_irq | output | 1 | Receive flag |
| tx_irq | output | 1 | Transmit flag |

## Verification
The bench builds the block with FIX_DIV at 2 and SYNC_DIV at 12, and it programs a divisor of 3. A mode-2 bit is therefore 32 clocks and a mode-1 or mode-3 bit is 64 clocks. With these settings, each mode's full frame, the double-buffer refusal and the framing-error sequence all complete within a few thousand cycles. The tick period of 2 or 4 clocks also lets the bench place a glitch narrower than one tick inside a data bit. That glitch can hit at most one of the three votes, so the majority rule is exercised without the bench knowing the exact tick phase.

// File: rtl/usart_pkg.sv
package usart_pkg;

  typedef enum logic [1:0] {
    M_SYNC       = 2'd0,
    M_ASYNC8     = 2'd1,
    M_ASYNC9_FIX = 2'd2,
    M_ASYNC9_GEN = 2'd3
  } mode_e;

  localparam int FRAME_W = 11;

  // majority of three samples
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // bits in transmit order, LSB leaves first; unused high bits idle at 1
  function automatic logic [FRAME_W-1:0] tx_frame(input mode_e m, input logic [7:0] d,
                                                  input logic b9);
    case (m)
      M_SYNC:   return {3'b111, d};
      M_ASYNC8: return {2'b11, d, 1'b0};
      default:  return {1'b1, b9, d, 1'b0};
    endcase
  endfunction

  function automatic logic [3:0] frame_len(input mode_e m);
    case (m)
      M_SYNC:   return 4'd8;
      M_ASYNC8: return 4'd10;
      default:  return 4'd11;
    endcase
  endfunction

endpackage

// File: rtl/usart_baud.sv
module usart_baud
  import usart_pkg::*;
#(
  parameter int FIX_DIV = 4,
  parameter int DIVW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mode_e           mode,
  input  logic [DIVW-1:0] gen_div,
  output logic            tick
);
  localparam int FW = $clog2(FIX_DIV + 1);
  localparam int CW = (FW > DIVW + 1) ? FW : DIVW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    if (mode == M_ASYNC9_FIX) limit = CW'(FIX_DIV - 1);
    else                      limit = CW'(gen_div);
  end

  assign tick = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // with a period above one clock, a tick is never followed at once by another (R4)
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> !tick);

endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_pkg::*;
#(
  parameter int SYNC_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mode_e      mode,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] ldata,
  input  logic       tx9,
  output logic       txd,
  output logic       shclk,
  output logic       busy,
  output logic       tflag_set
);
  localparam int CW0 = (SYNC_DIV > 2) ? $clog2(SYNC_DIV) : 1;
  localparam logic [CW0-1:0] C0_LAST = CW0'(SYNC_DIV - 1);
  localparam logic [CW0-1:0] C0_HALF = CW0'(SYNC_DIV / 2);

  logic [FRAME_W-1:0] sh;
  logic [3:0]         nleft;
  logic [3:0]         tcnt;
  logic [CW0-1:0]     c0;
  logic               sync_q;
  logic               busy_q;

  logic start_ok, sync_step, async_step, step, last_bit;

  assign start_ok   = load && !busy_q;
  assign sync_step  = busy_q && sync_q && (c0 == C0_LAST);
  assign async_step = busy_q && !sync_q && tick && (tcnt == 4'd15);
  assign step       = sync_step || async_step;
  assign last_bit   = step && (nleft == 4'd1);
  assign tflag_set  = (sync_step && nleft == 4'd1) || (async_step && nleft == 4'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '1; nleft <= '0; tcnt <= '0; c0 <= '0; sync_q <= 1'b0; busy_q <= 1'b0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      sync_q <= (mode == M_SYNC);
      tcnt   <= '0;
      c0     <= '0;
      sh     <= tx_frame(mode, ldata, tx9);
      nleft  <= frame_len(mode);
    end else if (busy_q) begin
      if (sync_q) c0 <= sync_step ? '0 : c0 + 1'b1;
      else if (tick) tcnt <= tcnt + 1'b1;
      if (step) begin
        sh    <= {1'b1, sh[FRAME_W-1:1]};
        nleft <= nleft - 1'b1;
      end
      if (last_bit) busy_q <= 1'b0;
    end
  end

  assign txd   = busy_q ? sh[0] : 1'b1;
  assign shclk = (busy_q && sync_q) ? (c0 >= C0_HALF) : 1'b1;
  assign busy  = busy_q;

  // entering the stop bit: line high, frame still running (R5)
  p_stop_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tflag_set && !sync_q) |=> (txd && busy_q));
  // sync frame finishes with clock and data parked high (R2)
  p_sync_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tflag_set && sync_q) |=> (!busy_q && shclk && txd));
  // a load during a frame leaves the shift register alone (R12)
  p_busy_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy_q && !step) |=> $stable(sh));

endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_e      mode,
  input  logic       tick,
  input  logic       rxd,
  input  logic       rx_en,
  output logic       frame_end,
  output logic [7:0] frame_data,
  output logic       frame_b9,
  output logic       frame_stop
);
  logic       s1, s2;
  logic       active, nine_q, b9q;
  logic [3:0] tcnt, bidx;
  logic [1:0] samp;
  logic [7:0] dsh;

  logic       mid, vote, false_start;
  logic [3:0] stop_idx;

  assign mid         = active && tick && (tcnt == 4'd9);
  assign vote        = maj3({samp, s2});
  assign stop_idx    = nine_q ? 4'd10 : 4'd9;
  assign frame_end   = mid && (bidx == stop_idx);
  assign false_start = mid && (bidx == 4'd0) && vote;
  assign frame_stop  = vote;
  assign frame_data  = dsh;
  assign frame_b9    = nine_q ? b9q : vote;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1;
      active <= 1'b0; nine_q <= 1'b0; b9q <= 1'b0;
      tcnt <= '0; bidx <= '0; samp <= '0; dsh <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (tick) begin
        if (!active) begin
          if (rx_en && !s2 && mode != M_SYNC) active <= 1'b1;
          tcnt   <= '0;
          bidx   <= '0;
          nine_q <= mode[1];
        end else begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd7 || tcnt == 4'd8) samp <= {samp[0], s2};
          if (tcnt == 4'd15) bidx <= bidx + 1'b1;
          if (mid) begin
            if (false_start) active <= 1'b0;
            else if (bidx >= 4'd1 && bidx <= 4'd8) dsh <= {vote, dsh[7:1]};
            else if (bidx == 4'd9 && nine_q) b9q <= vote;
            if (frame_end) active <= 1'b0;
          end
        end
      end
    end
  end

  // the receiver is idle straight after a frame or a rejected start (R7, R8)
  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !active);
  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> !active);
  p_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bidx <= 4'd10));

endmodule

// File: rtl/usart_core.sv
module usart_core
  import usart_pkg::*;
#(
  parameter int FIX_DIV  = 4,
  parameter int SYNC_DIV = 12,
  parameter int DIVW     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       shclk,
  output logic       rx_irq,
  output logic       tx_irq
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CFG  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_BAUD = 2'd3;

  logic [1:0]      mode_q;
  logic            rx_en_q, tx9_q, rx9_q, tflag_q, rflag_q, fe_q, fe_en_q;
  logic [7:0]      rbuf_q;
  logic [DIVW-1:0] bdiv_q;
  mode_e           cur_mode;

  logic wr_ctrl, wr_cfg, wr_data, wr_baud;
  logic tick, tx_busy, tflag_set;
  logic frame_end, frame_b9, frame_stop, take;
  logic [7:0] frame_data;

  assign cur_mode = mode_e'(mode_q);
  assign wr_ctrl  = reg_we && reg_sel == SEL_CTRL;
  assign wr_cfg   = reg_we && reg_sel == SEL_CFG;
  assign wr_data  = reg_we && reg_sel == SEL_DATA;
  assign wr_baud  = reg_we && reg_sel == SEL_BAUD;
  assign take     = frame_end && !rflag_q;

  usart_baud #(.FIX_DIV(FIX_DIV), .DIVW(DIVW)) u_baud (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode), .gen_div(bdiv_q), .tick(tick));

  usart_tx #(.SYNC_DIV(SYNC_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode), .tick(tick), .load(wr_data),
    .ldata(reg_wdata), .tx9(tx9_q), .txd(txd), .shclk(shclk), .busy(tx_busy),
    .tflag_set(tflag_set));

  usart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode), .tick(tick), .rxd(rxd), .rx_en(rx_en_q),
    .frame_end(frame_end), .frame_data(frame_data), .frame_b9(frame_b9),
    .frame_stop(frame_stop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; rx_en_q <= 1'b0; tx9_q <= 1'b0; rx9_q <= 1'b0;
      tflag_q <= 1'b0; rflag_q <= 1'b0; fe_q <= 1'b0; fe_en_q <= 1'b0;
      rbuf_q <= '0; bdiv_q <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q[0] <= reg_wdata[6];
        if (fe_en_q) fe_q <= fe_q & reg_wdata[7];
        else         mode_q[1] <= reg_wdata[7];
        rx_en_q <= reg_wdata[5];
        tx9_q   <= reg_wdata[4];
        rx9_q   <= reg_wdata[3];
        tflag_q <= reg_wdata[2];
        rflag_q <= reg_wdata[1];
      end
      if (wr_cfg)  fe_en_q <= reg_wdata[0];
      if (wr_baud) bdiv_q  <= DIVW'(reg_wdata);
      if (tflag_set) tflag_q <= 1'b1;
      if (take) begin
        rbuf_q  <= frame_data;
        rx9_q   <= frame_b9;
        rflag_q <= 1'b1;
      end
      if (frame_end && !frame_stop) fe_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {(fe_en_q ? fe_q : mode_q[1]), mode_q[0], rx_en_q, tx9_q,
                             rx9_q, tflag_q, rflag_q, 1'b0};
      SEL_CFG:  reg_rdata = {7'd0, fe_en_q};
      SEL_DATA: reg_rdata = rbuf_q;
      default:  reg_rdata = 8'(bdiv_q);
    endcase
  end

  assign rx_irq = rflag_q;
  assign tx_irq = tflag_q;

  // a full buffer is not overwritten by the receiver (R9)
  p_buf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rflag_q && !wr_ctrl) |=> ($stable(rbuf_q) && $stable(rx9_q) && rflag_q));
  // framing error stays until software clears it (R10)
  p_fe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !(wr_ctrl && fe_en_q)) |=> fe_q);
  // idle transmitter leaves both pins high (R1)
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (txd && shclk));

endmodule

// File: tb/sim_usart_core.sv
module sim_usart_core;
  localparam int CLK_PERIOD = 10;
  localparam int FIXD = 2;
  localparam int SDIV = 12;
  localparam int BDIV = 3;
  localparam int BP_GEN = 16 * (BDIV + 1);
  localparam int BP_FIX = 16 * FIXD;

  logic clk, rst_n, reg_we, rxd;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic txd, shclk, rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;
  bit m_sync = 0;

  usart_core #(.FIX_DIV(FIXD), .SYNC_DIV(SDIV), .DIVW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd), .shclk(shclk), .rx_irq(rx_irq),
    .tx_irq(tx_irq));

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  function automatic logic [7:0] mk(input int mode, input bit rxen, input bit t9);
    return {2'(mode), rxen, t9, 4'b0000};
  endfunction

  // per-clock model: shift clock only moves during a sync frame (R2, R3)
  always @(negedge clk) if (rst_n && !m_sync) check("R3 shclk idle", shclk, 1);

  task automatic tx_async(input logic [7:0] d, input bit nine, input bit b9, input int bp,
                          input bit extra, input string req);
    int w = 0;
    int lows = 0;
    wr(2, d);
    if (extra) wr(2, 8'hFF);
    while (txd !== 1'b0 && w < 4 * bp) begin @(negedge clk); w++; end
    tick_n(bp / 2);
    check({req, " start"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      tick_n(bp);
      check({req, " data"}, txd, d[i]);
    end
    if (nine) begin tick_n(bp); check({req, " ninth"}, txd, b9); end
    check("R5 flag before stop", tx_irq, 0);
    tick_n(bp / 2 + 4);
    check("R5 flag at stop", tx_irq, 1);
    check({req, " stop"}, txd, 1);
    tick_n(bp);
    if (extra) begin
      for (int i = 0; i < 3 * bp; i++) begin @(negedge clk); if (!txd) lows++; end
      check("R12 busy write ignored", lows, 0);
    end
  endtask

  task automatic tx_sync(input logic [7:0] d);
    int last = 0;
    int now = 0;
    logic prev;
    m_sync = 1;
    wr(2, d);
    prev = shclk;
    for (int i = 0; i < 8; i++) begin
      int w = 0;
      while (!(prev == 1'b0 && shclk == 1'b1) && w < 3 * SDIV) begin
        prev = shclk; @(negedge clk); now++; w++;
      end
      prev = shclk;
      check("R2 sync bit", txd, d[i]);
      if (i > 0) check("R2 shift period", now - last, SDIV);
      last = now;
    end
    tick_n(SDIV);
    check("R2 sync flag", tx_irq, 1);
    check("R2 shclk park", shclk, 1);
    check("R2 txd park", txd, 1);
    m_sync = 0;
  endtask

  task automatic rx_send(input logic [7:0] d, input bit nine, input bit b9, input bit stop,
                         input int bp, input int gbit);
    logic [10:0] f;
    int n;
    int p = bp / 16;
    f = nine ? {stop, b9, d, 1'b0} : {1'b0, stop, d, 1'b0};
    n = nine ? 11 : 10;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = f[i];
      if (i == gbit) begin
        tick_n(8 * p - 1); rxd = ~f[i];
        tick_n(p - 1);     rxd = f[i];
        tick_n(bp - 9 * p + 1);
      end else tick_n(bp - 1);
    end
    @(negedge clk); rxd = 1;
    tick_n(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; rxd = 1; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    tick_n(4);
    rst_n = 1;
    tick_n(1);
    // R1
    check("R1 txd", txd, 1);
    check("R1 shclk", shclk, 1);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 tx_irq", tx_irq, 0);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(2, v); check("R1 data", v, 0);

    wr(3, 8'(BDIV));
    // R2 sync mode
    wr(0, mk(0, 0, 0));
    tx_sync(8'hA5);
    // R3 + R12 mode 1
    wr(0, mk(1, 0, 0));
    tx_async(8'h3C, 0, 0, BP_GEN, 1, "R3");
    // R4 mode 3 and mode 2
    wr(0, mk(3, 0, 1));
    tx_async(8'h96, 1, 1, BP_GEN, 0, "R4 mode3");
    wr(0, mk(2, 0, 0));
    tx_async(8'h5A, 1, 0, BP_FIX, 0, "R4 mode2");

    // R8 receive in mode 1
    wr(0, mk(1, 1, 0));
    rx_send(8'hC3, 0, 0, 1, BP_GEN, -1);
    check("R8 rx flag", rx_irq, 1);
    rd(2, v); check("R8 rx data", v, 8'hC3);
    rd(0, v); check("R8 stop into bit3", v[3], 1);
    // R9 buffer full, new frame refused
    rx_send(8'h11, 0, 0, 1, BP_GEN, -1);
    rd(2, v); check("R9 buffer kept", v, 8'hC3);
    check("R9 flag kept", rx_irq, 1);

    // R6 glitch in mode 3, ninth 1
    wr(0, mk(3, 1, 0));
    rx_send(8'h6E, 1, 1, 1, BP_GEN, 3);
    rd(2, v); check("R6 mode3 glitch data", v, 8'h6E);
    rd(0, v); check("R8 ninth bit", v[3], 1);
    // R6 mode 2, ninth 0
    wr(0, mk(2, 1, 0));
    rx_send(8'h81, 1, 0, 1, BP_FIX, 8);
    rd(2, v); check("R6 mode2 glitch data", v, 8'h81);
    rd(0, v); check("R8 ninth bit zero", v[3], 0);

    // R7 false start
    wr(0, mk(1, 1, 0));
    @(negedge clk); rxd = 0;
    tick_n(3 * (BDIV + 1));
    rxd = 1;
    tick_n(3 * BP_GEN);
    check("R7 false start", rx_irq, 0);
    rd(2, v); check("R7 buffer unchanged", v, 8'h81);

    // R11 receiver disabled
    wr(0, mk(1, 0, 0));
    rx_send(8'h42, 0, 0, 1, BP_GEN, -1);
    check("R11 disabled flag", rx_irq, 0);
    rd(2, v); check("R11 disabled data", v, 8'h81);

    // R10 framing error
    wr(1, 8'h01);
    wr(0, mk(1, 1, 0));
    rx_send(8'h55, 0, 0, 0, BP_GEN, -1);
    tick_n(2 * BP_GEN);
    rd(0, v); check("R10 fe visible", v[7], 1);
    check("R10 mode kept", v[6], 1);
    wr(0, 8'h80 | mk(1, 1, 0));
    rx_send(8'h24, 0, 0, 1, BP_GEN, -1);
    rd(2, v); check("R10 good frame data", v, 8'h24);
    rd(0, v); check("R10 fe sticky", v[7], 1);
    wr(0, mk(1, 1, 0));
    rd(0, v); check("R10 fe cleared", v[7], 0);
    wr(1, 8'h00);
    wr(0, mk(3, 0, 0));
    rd(0, v); check("R10 bit7 is mode", v[7], 1);

    tick_n(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule